// File: doc/BRIEF.md
# Word Stack Push/Pop Engine

This block runs 16-bit stack transfers against a memory that is one byte wide. A command asks for a push of a word or a pop into a numbered destination register. The engine splits each word into two byte accesses, forms every physical address from a 16-bit stack segment value and an internal 16-bit stack pointer, and moves the pointer by two once both bytes have been transferred.

The physical address is the segment value shifted left by four bits plus the pointer, truncated to 20 bits. On a push, the upper byte is stored just below the pointer and the lower byte one byte further down. On a pop, the lower byte is read at the pointer and the upper byte at the next address up. A pop whose destination is the code segment register is refused: no memory is touched, nothing is updated, and a one-cycle error flag is raised. The engine accepts one command at a time and reports completion with a single-cycle done pulse that also carries the popped word and its destination identifier.

Top module: `stk_word_engine`

## Requirements
- R1: A push writes the upper byte of the word at offset SP-1 in its first memory cycle and the lower byte at offset SP-2 in its second memory cycle, with mem_we_o high in both.
- R2: A pop reads offset SP in its first memory cycle and SP+1 in its second, with mem_we_o low. Read data arrives on mem_rdata_i one cycle after the read is presented. pop_word_o is {byte read at SP+1, byte read at SP} and pop_reg_o is the requested destination, both valid while done_o is high.
- R3: Every memory address equals (stack segment << 4) + offset modulo 2^20. The segment is sampled when the command is accepted.
- R4: On completion, a push lowers sp_o by 2 and a pop raises it by 2, modulo 2^16 in both cases. sp_o changes only in the cycle in which done_o is high.
- R5: An accepted legal command drives mem_en_o high in exactly the two cycles after the accepting edge. done_o is then high for exactly one cycle, beginning at the third edge after acceptance.
- R6: A command is accepted only while busy_o is low. Commands presented while busy_o is high are ignored and cause no memory access and no pointer change.
- R7: A pop whose destination equals CODE_SEG_ID (1 by default) makes no memory access, does not pulse done_o, leaves sp_o and pop_word_o unchanged, and raises err_o for exactly the one cycle after the accepting edge.
- R8: After reset, sp_o equals SP_INIT and busy_o, mem_en_o, mem_we_o, done_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_push_i | input | 1 | 1 = push, 0 = pop |
| cmd_word_i | input | 16 | Word to push |
| cmd_reg_i | input | 3 | Destination register identifier for a pop |
| stk_seg_i | input | 16 | Stack segment value |
| busy_o | output | 1 | Operation in progress |
| mem_en_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 20 | Physical byte address |
| mem_wdata_o | output | 8 | Byte to write |
| mem_rdata_i | input | 8 | Byte read, one cycle after the read |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Refused pop pulse |
| pop_word_o | output | 16 | Word returned by the last pop |
| pop_reg_o | output | 3 | Destination of the last pop |
| sp_o | output | 16 | Current stack pointer |

## Verification
The accept path and the completion path can both act in the same cycle. A new command may arrive in the cycle in which done_o is high, and a command held valid throughout a busy operation reaches the engine on the edge after its completion. The bench holds cmd_valid_i high across a whole push and checks that exactly two writes occur and that the pointer moves only once. Pointer wrap in both directions and 20-bit address wrap are exercised with a pointer that starts close to zero and with a segment value of FFFFh.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC1 = 2'd1,
    ST_ACC2 = 2'd2,
    ST_FIN  = 2'd3
  } stk_state_e;

  localparam int unsigned STK_PHASES = 2;
endpackage

// File: rtl/stk_addr_gen.sv
module stk_addr_gen #(
  parameter int unsigned SEG_W     = 16,
  parameter int unsigned PTR_W     = 16,
  parameter int unsigned SEG_SHIFT = 4,
  localparam int unsigned ADDR_W   = SEG_W + SEG_SHIFT
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [PTR_W-1:0]  sp_i,
  input  logic              push_i,
  output logic [ADDR_W-1:0] addr_first_o,
  output logic [ADDR_W-1:0] addr_second_o
);
  logic [ADDR_W-1:0] phys [stk_pkg::STK_PHASES];

  // Phase k: push uses SP-(k+1), pop uses SP+k; offsets wrap in the segment.
  for (genvar k = 0; k < stk_pkg::STK_PHASES; k++) begin : g_phase
    logic [PTR_W-1:0] off;
    always_comb begin
      if (push_i) off = sp_i - PTR_W'(k + 1);
      else        off = sp_i + PTR_W'(k);
      phys[k] = {seg_i, {SEG_SHIFT{1'b0}}} + {{(ADDR_W-PTR_W){1'b0}}, off};
    end
  end

  assign addr_first_o  = phys[0];
  assign addr_second_o = phys[1];
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int unsigned PTR_W = 16,
  parameter logic [PTR_W-1:0] SP_INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec_i,
  input  logic             inc_i,
  output logic [PTR_W-1:0] sp_o
);
  localparam logic [PTR_W-1:0] STEP = PTR_W'(2);

  always_ff @(posedge clk) begin
    if (rst)        sp_o <= SP_INIT;
    else if (dec_i) sp_o <= sp_o - STEP;
    else if (inc_i) sp_o <= sp_o + STEP;
  end

  // R4: increment and decrement requests never coincide.
  p_single_step_r4: assert property (@(posedge clk) disable iff (rst)
    !(dec_i && inc_i));
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl #(
  parameter int unsigned SEG_W       = 16,
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned REG_W       = 3,
  parameter int unsigned ADDR_W      = 20,
  parameter logic [REG_W-1:0] CODE_SEG_ID = 3'd1,
  localparam int unsigned BYTE_W     = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid_i,
  input  logic              cmd_push_i,
  input  logic [WORD_W-1:0] cmd_word_i,
  input  logic [REG_W-1:0]  cmd_reg_i,
  input  logic [SEG_W-1:0]  seg_i,
  output logic [SEG_W-1:0]  seg_cur_o,
  output logic              push_cur_o,
  input  logic [ADDR_W-1:0] addr_first_i,
  input  logic [ADDR_W-1:0] addr_second_i,
  output logic              busy_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [WORD_W-1:0] pop_word_o,
  output logic [REG_W-1:0]  pop_reg_o,
  output logic              sp_dec_o,
  output logic              sp_inc_o
);
  import stk_pkg::*;

  stk_state_e          state_q;
  logic [SEG_W-1:0]    seg_q;
  logic                push_q;
  logic [WORD_W-1:0]   word_q;
  logic [REG_W-1:0]    reg_q;
  logic [BYTE_W-1:0]   lo_q;
  logic                idle, accept, refuse;

  assign idle   = (state_q == ST_IDLE);
  assign accept = idle && cmd_valid_i;
  assign refuse = accept && !cmd_push_i && (cmd_reg_i == CODE_SEG_ID);

  // Address generator sees live inputs while idle, latched ones while busy.
  assign seg_cur_o  = idle ? seg_i      : seg_q;
  assign push_cur_o = idle ? cmd_push_i : push_q;
  assign busy_o     = !idle;

  assign sp_dec_o = (state_q == ST_FIN) &&  push_q;
  assign sp_inc_o = (state_q == ST_FIN) && !push_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      seg_q       <= '0;
      push_q      <= 1'b0;
      word_q      <= '0;
      reg_q       <= '0;
      lo_q        <= '0;
      mem_en_o    <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      pop_word_o  <= '0;
      pop_reg_o   <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (refuse) begin
            err_o <= 1'b1;
          end else if (accept) begin
            state_q     <= ST_ACC1;
            seg_q       <= seg_i;
            push_q      <= cmd_push_i;
            word_q      <= cmd_word_i;
            reg_q       <= cmd_reg_i;
            mem_en_o    <= 1'b1;
            mem_we_o    <= cmd_push_i;
            mem_addr_o  <= addr_first_i;
            mem_wdata_o <= cmd_push_i ? cmd_word_i[WORD_W-1:BYTE_W] : '0;
          end
        end
        ST_ACC1: begin
          state_q     <= ST_ACC2;
          mem_addr_o  <= addr_second_i;
          mem_wdata_o <= push_q ? word_q[BYTE_W-1:0] : '0;
        end
        ST_ACC2: begin
          state_q     <= ST_FIN;
          mem_en_o    <= 1'b0;
          mem_we_o    <= 1'b0;
          mem_wdata_o <= '0;
          if (!push_q) lo_q <= mem_rdata_i;
        end
        ST_FIN: begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
          if (!push_q) begin
            pop_word_o <= {mem_rdata_i, lo_q};
            pop_reg_o  <= reg_q;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5: completion is a single-cycle pulse.
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5: a memory burst lasts exactly two cycles.
  p_mem_burst_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_en_o) |=> mem_en_o);
  p_mem_end_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_en_o && $past(mem_en_o)) |=> !mem_en_o);

  // R7: a refused pop leaves the memory port quiet and the engine idle.
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!mem_en_o && !busy_o && !done_o));

  // R6: no write strobe outside a memory cycle.
  p_we_in_burst_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> mem_en_o);
endmodule

// File: rtl/stk_word_engine.sv
module stk_word_engine #(
  parameter int unsigned SEG_W       = 16,
  parameter int unsigned PTR_W       = 16,
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned REG_W       = 3,
  parameter int unsigned SEG_SHIFT   = 4,
  parameter logic [REG_W-1:0] CODE_SEG_ID = 3'd1,
  parameter logic [PTR_W-1:0] SP_INIT     = 16'h0000,
  localparam int unsigned ADDR_W     = SEG_W + SEG_SHIFT,
  localparam int unsigned BYTE_W     = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid_i,
  input  logic              cmd_push_i,
  input  logic [WORD_W-1:0] cmd_word_i,
  input  logic [REG_W-1:0]  cmd_reg_i,
  input  logic [SEG_W-1:0]  stk_seg_i,
  output logic              busy_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [WORD_W-1:0] pop_word_o,
  output logic [REG_W-1:0]  pop_reg_o,
  output logic [PTR_W-1:0]  sp_o
);
  logic [SEG_W-1:0]  seg_cur;
  logic              push_cur;
  logic [ADDR_W-1:0] addr_first, addr_second;
  logic              sp_dec, sp_inc;

  stk_addr_gen #(
    .SEG_W(SEG_W), .PTR_W(PTR_W), .SEG_SHIFT(SEG_SHIFT)
  ) u_addr (
    .seg_i(seg_cur), .sp_i(sp_o), .push_i(push_cur),
    .addr_first_o(addr_first), .addr_second_o(addr_second)
  );

  stk_ctrl #(
    .SEG_W(SEG_W), .WORD_W(WORD_W), .REG_W(REG_W),
    .ADDR_W(ADDR_W), .CODE_SEG_ID(CODE_SEG_ID)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_valid_i(cmd_valid_i), .cmd_push_i(cmd_push_i),
    .cmd_word_i(cmd_word_i), .cmd_reg_i(cmd_reg_i),
    .seg_i(stk_seg_i), .seg_cur_o(seg_cur), .push_cur_o(push_cur),
    .addr_first_i(addr_first), .addr_second_i(addr_second),
    .busy_o(busy_o), .mem_en_o(mem_en_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .done_o(done_o), .err_o(err_o),
    .pop_word_o(pop_word_o), .pop_reg_o(pop_reg_o),
    .sp_dec_o(sp_dec), .sp_inc_o(sp_inc)
  );

  stk_ptr #(.PTR_W(PTR_W), .SP_INIT(SP_INIT)) u_ptr (
    .clk(clk), .rst(rst), .dec_i(sp_dec), .inc_i(sp_inc), .sp_o(sp_o)
  );

  // R4: the pointer moves only together with the completion pulse.
  p_sp_with_done_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sp_o) |-> done_o);

  // R7: a refused pop never moves the pointer.
  p_sp_hold_err_r7: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $stable(sp_o));
endmodule

// File: tb/stk_word_engine_bench.sv
`timescale 1ns/1ps
module stk_word_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_push = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [2:0]  cmd_reg = '0;
  logic [15:0] seg = 16'h1234;
  logic        busy, mem_en, mem_we, done, err;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] pop_word, sp;
  logic [2:0]  pop_reg;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] sp_exp;

  logic [7:0]  mem_model [int];
  logic [19:0] log_addr [8];
  logic        log_we   [8];
  logic [7:0]  log_data [8];
  int          log_n = 0;

  always #2.5 clk = ~clk;

  stk_word_engine #(.SP_INIT(16'h0004)) u_stk_word_engine (
    .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid), .cmd_push_i(cmd_push),
    .cmd_word_i(cmd_word), .cmd_reg_i(cmd_reg), .stk_seg_i(seg),
    .busy_o(busy), .mem_en_o(mem_en), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .done_o(done), .err_o(err), .pop_word_o(pop_word), .pop_reg_o(pop_reg),
    .sp_o(sp)
  );

  // Byte memory with one cycle of read latency, plus an access log.
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem_model[int'(mem_addr)] = mem_wdata;
      else mem_rdata <= mem_model.exists(int'(mem_addr)) ? mem_model[int'(mem_addr)] : 8'h00;
      if (log_n < 8) begin
        log_addr[log_n] = mem_addr;
        log_we[log_n]   = mem_we;
        log_data[log_n] = mem_wdata;
      end
      log_n = log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return 20'({s, 4'h0} + {4'h0, o});
  endfunction

  // Presents a command for one edge; returns at the negedge after acceptance.
  task automatic issue(input logic p, input logic [15:0] w, input logic [2:0] r);
    @(negedge clk);
    log_n = 0;
    cmd_valid = 1'b1; cmd_push = p; cmd_word = w; cmd_reg = r;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    chk(busy == 1'b1, {tag, " R6 busy after accept"}, busy, 1);
    chk(mem_en == 1'b1, {tag, " R5 mem_en cycle1"}, mem_en, 1);
    @(negedge clk);
    chk(mem_en == 1'b1, {tag, " R5 mem_en cycle2"}, mem_en, 1);
    @(negedge clk);
    chk(mem_en == 1'b0 && done == 1'b0, {tag, " R5 gap cycle"}, {mem_en, done}, 0);
    @(negedge clk);
    chk(done == 1'b1, {tag, " R5 done pulse"}, done, 1);
  endtask

  task automatic t_push(input logic [15:0] w);
    logic [15:0] s0 = sp_exp;
    issue(1'b1, w, 3'd0);
    wait_done("push");
    sp_exp = s0 - 16'd2;
    chk(sp == sp_exp, "R4 sp after push", sp, sp_exp);
    @(negedge clk);
    chk(done == 1'b0, "R5 done single cycle", done, 0);
    chk(log_n == 2, "R5 two accesses", log_n, 2);
    chk(log_we[0] && log_addr[0] == phys(seg, s0 - 16'd1) && log_data[0] == w[15:8],
        "R1 R3 high byte first", {log_addr[0], log_data[0]}, {phys(seg, s0 - 16'd1), w[15:8]});
    chk(log_we[1] && log_addr[1] == phys(seg, s0 - 16'd2) && log_data[1] == w[7:0],
        "R1 R3 low byte second", {log_addr[1], log_data[1]}, {phys(seg, s0 - 16'd2), w[7:0]});
  endtask

  task automatic t_pop(input logic [2:0] r, input logic [15:0] w_exp);
    logic [15:0] s0 = sp_exp;
    issue(1'b0, 16'h0, r);
    wait_done("pop");
    sp_exp = s0 + 16'd2;
    chk(sp == sp_exp, "R4 sp after pop", sp, sp_exp);
    chk(pop_word == w_exp, "R2 popped word", pop_word, w_exp);
    chk(pop_reg == r, "R2 pop destination", pop_reg, r);
    @(negedge clk);
    chk(log_n == 2, "R5 two accesses", log_n, 2);
    chk(!log_we[0] && log_addr[0] == phys(seg, s0), "R2 R3 read low at SP",
        log_addr[0], phys(seg, s0));
    chk(!log_we[1] && log_addr[1] == phys(seg, s0 + 16'd1), "R2 R3 read high at SP+1",
        log_addr[1], phys(seg, s0 + 16'd1));
  endtask

  task automatic t_pop_code_seg();
    logic [15:0] w0 = pop_word;
    issue(1'b0, 16'h0, 3'd1);
    chk(err == 1'b1, "R7 err raised", err, 1);
    chk(busy == 1'b0, "R7 stays idle", busy, 0);
    @(negedge clk);
    chk(err == 1'b0, "R7 err one cycle", err, 0);
    repeat (3) begin
      @(negedge clk);
      chk(done == 1'b0, "R7 no done", done, 0);
    end
    chk(log_n == 0, "R7 no memory access", log_n, 0);
    chk(sp == sp_exp, "R7 sp unchanged", sp, sp_exp);
    chk(pop_word == w0, "R7 pop word unchanged", pop_word, w0);
  endtask

  // Command held valid through the whole operation: only the first is taken,
  // the held one lands on the edge after done and is dropped at that negedge.
  task automatic t_busy_ignore(input logic [15:0] w);
    logic [15:0] s0 = sp_exp;
    @(negedge clk);
    log_n = 0;
    cmd_valid = 1'b1; cmd_push = 1'b1; cmd_word = w; cmd_reg = 3'd0;
    repeat (4) @(negedge clk);
    cmd_valid = 1'b0;
    chk(done == 1'b1, "R6 done with held command", done, 1);
    sp_exp = s0 - 16'd2;
    chk(sp == sp_exp, "R6 pointer moved once", sp, sp_exp);
    chk(log_n == 2, "R6 held command ignored while busy", log_n, 2);
    @(negedge clk);
    chk(busy == 1'b0 && sp == sp_exp, "R6 nothing started after drop", {busy, sp}, {1'b0, sp_exp});
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk(sp == 16'h0004, "R8 sp reset", sp, 16'h0004);
    chk({busy, mem_en, mem_we, done, err} == 5'b0, "R8 outputs idle",
        {busy, mem_en, mem_we, done, err}, 0);
    sp_exp = 16'h0004;

    t_push(16'hA1B2);            // sp 4 -> 2
    t_push(16'hC3D4);            // sp 2 -> 0
    t_push(16'hE5F6);            // R4 wrap down: sp 0 -> FFFE
    t_pop(3'd2, 16'hE5F6);       // R4 wrap up: FFFE -> 0
    t_pop(3'd5, 16'hC3D4);       // 0 -> 2
    t_pop_code_seg();            // R7
    t_busy_ignore(16'h1357);     // R6, sp 2 -> 0
    seg = 16'hFFFF;              // R3 20-bit wrap of the address
    t_push(16'h2468);
    t_pop(3'd0, 16'h2468);
    seg = 16'h1234;
    t_pop(3'd3, 16'h1357);
    t_pop(3'd4, 16'hA1B2);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule